// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

The block holds three independent 32-bit down-counters behind a small word-addressed register port. Each channel decrements once per count tick while its bit in a shared run register is set. The tick comes either from one of five taps on a free-running prescaler or from a chosen edge of that channel's external clock pin. When a counter steps down from zero it takes the value of its reload register in the same tick and keeps running. It also raises a sticky underflow flag, which drives an interrupt line when the channel's interrupt enable is set.

The last channel can also latch its live count into a capture register on an edge of a dedicated capture pin. This sets a capture flag with its own interrupt. Software clears flags by writing zero to them. A read returns its data one cycle after the read strobe, marked by a valid pulse.

Word map: 0 is the run register, where bit c starts channel c. Channel c occupies words 4+4c to 7+4c, holding the reload value, the counter, the control word and the capture register, in that order.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the run register and every control word read 0, every counter and reload register reads 0xFFFFFFFF, and all interrupt outputs are low.
- R2: A counter decrements by exactly one per count tick only while its run bit is 1. With the run bit at 0 it holds its value.
- R3: Control bits [2:0] select the tick source. Codes 0, 1, 2, 3 and 4 give one tick every 4, 16, 64, 256 and 1024 clock cycles.
- R4: A tick that finds the counter at 0 loads the reload value instead of decrementing, so a reload value N gives a period of N+1 ticks.
- R5: That reload tick sets the underflow flag (control bit 8), which stays set until software clears it.
- R6: Writing a control word with a flag bit at 0 clears that flag, and writing 1 leaves it unchanged. A flag-setting event in the same cycle as a clearing write leaves the flag set.
- R7: A channel's underflow interrupt output equals its underflow flag ANDed with its enable bit (control bit 5).
- R8: Codes 5 to 7 in bits [2:0] count edges of the channel's external pin, after a two-flop synchroniser. Bits [4:3] pick the edge: 00 rising, 01 falling, 1x both.
- R9: Only the last channel captures. Its mode field (bits [7:6]) selects the behaviour: 0x means off, 10 means capture, and 11 means capture with interrupt. An edge of the capture pin, chosen by bits [4:3], copies the counter into word 15 and sets the capture flag (bit 9). The capture interrupt is that flag ANDed with mode 11. On other channels the mode field reads 0.
- R10: The counter and reload registers can be written independently while a channel is stopped. Writing one does not change the other.
- R11: Read data is valid, with the valid strobe high, in the cycle after the read strobe, and the strobe is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| ext_clk_i | input | 3 | External count pin per channel |
| capt_i | input | 1 | Capture pin of the last channel |
| unf_irq_o | output | 3 | Underflow interrupt per channel |
| capt_irq_o | output | 1 | Capture interrupt |

## Verification
Internal counting is tried with run windows that are whole multiples of the selected divide ratio. This makes the tick count independent of the prescaler phase, and it separates the ratios 4, 16 and 64 from one another. A window that crosses zero tells a reload of N apart from N-1 or from a wrap to all ones. External counting runs the same pulse train under rising, falling and both-edge selection, which must give 3, 3 and 6 steps. An external edge is timed to land on the same cycle as a flag-clearing write, exposing which of the two wins. Capture is exercised in its off mode, its silent mode and its interrupt mode.

// File: rtl/tmr_pkg.sv
// Package: shared types and register layout for the reloading timer.
// Assumes word addressing; offsets inside a channel window are fixed.
package tmr_pkg;
    localparam int CH_BASE    = 4;
    localparam int CH_STRIDE  = 4;
    localparam int OFS_RELOAD = 0;
    localparam int OFS_COUNT  = 1;
    localparam int OFS_CTRL   = 2;
    localparam int OFS_CAPT   = 3;

    // Control word, LSB first: clk_sel[2:0], edge_sel[4:3], unie[5],
    // capt_mode[7:6], unf_flag[8], capt_flag[9].
    typedef struct packed {
        logic       capt_flag;
        logic       unf_flag;
        logic [1:0] capt_mode;
        logic       unie;
        logic [1:0] edge_sel;
        logic [2:0] clk_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescale.sv
// Free-running prescaler: tick[k] pulses for one cycle every 4^(k+1) clocks.
// Assumes the taps are consumed in the same cycle; the phase is not tied to any start.
module tmr_prescale #(
    parameter int NDIV = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [NDIV-1:0] tick
);
    localparam int PW = 2 * NDIV;

    logic [PW-1:0] pre_q;

    // Advance the divider chain every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    for (genvar k = 0; k < NDIV; k++) begin : g_tap
        assign tick[k] = &pre_q[2*k+1:0];
    end

    for (genvar k = 0; k + 1 < NDIV; k++) begin : g_chk
        AST_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
            tick[k+1] |-> tick[k]); // R3
    end
endmodule

// File: rtl/tmr_edge_det.sv
// Synchronises an asynchronous pin with two flops and flags the selected edge.
// Assumes the pin stays stable for at least two clocks between changes.
module tmr_edge_det (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    logic meta_q, sync_q, prev_q;
    logic rise, fall;

    // Two-flop synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;

    // Pick rising, falling or either edge.
    always_comb begin
        if (edge_sel[1])      hit = rise | fall;
        else if (edge_sel[0]) hit = fall;
        else                  hit = rise;
    end
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: down-counter, reload register, control word, flags,
// and an optional capture register when HAS_CAPT is set.
// Assumes at most one register write per cycle; a software counter write beats counting.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NDIV     = 5,
    parameter bit HAS_CAPT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [NDIV-1:0]  div_tick,
    input  logic             ext_pin,
    input  logic             capt_pin,
    input  logic             reload_wr,
    input  logic             count_wr,
    input  logic             ctrl_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] capt_q,
    output ctrl_t            ctrl_q,
    output logic             unf_irq,
    output logic             capt_irq
);
    ctrl_t wd;
    logic  int_tick, ext_hit, tick, underflow, capt_ev;

    assign wd = ctrl_t'(wdata[CTRL_W-1:0]);

    // Select the prescaler tap named by clk_sel.
    always_comb begin
        int_tick = 1'b0;
        for (int k = 0; k < NDIV; k++)
            if (ctrl_q.clk_sel == 3'(k)) int_tick = div_tick[k];
    end

    tmr_edge_det u_ext (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin),
        .edge_sel(ctrl_q.edge_sel), .hit(ext_hit)
    );

    assign tick      = (ctrl_q.clk_sel >= 3'(NDIV)) ? ext_hit : int_tick;
    assign underflow = run && tick && !count_wr && (count_q == '0);

    // Reload register: software write only.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '1;
        else if (reload_wr) reload_q <= wdata;
    end

    // Counter: software load, else decrement or reload on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                count_q <= '1;
        else if (count_wr)         count_q <= wdata;
        else if (run && tick) begin
            if (count_q == '0)     count_q <= reload_q;
            else                   count_q <= count_q - 1'b1;
        end
    end

    // Control fields and sticky flags; a setting event beats a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else begin
            if (ctrl_wr) begin
                ctrl_q.clk_sel   <= wd.clk_sel;
                ctrl_q.edge_sel  <= wd.edge_sel;
                ctrl_q.unie      <= wd.unie;
                ctrl_q.capt_mode <= HAS_CAPT ? wd.capt_mode : 2'b00;
            end
            ctrl_q.unf_flag  <= underflow | (ctrl_q.unf_flag & ~(ctrl_wr & ~wd.unf_flag));
            ctrl_q.capt_flag <= capt_ev | (ctrl_q.capt_flag & ~(ctrl_wr & ~wd.capt_flag));
        end
    end

    if (HAS_CAPT) begin : g_capt
        logic capt_hit;

        tmr_edge_det u_capt (
            .clk(clk), .rst_n(rst_n), .pin(capt_pin),
            .edge_sel(ctrl_q.edge_sel), .hit(capt_hit)
        );

        assign capt_ev = capt_hit & ctrl_q.capt_mode[1];

        // Latch the live count on an enabled capture edge.
        always_ff @(posedge clk) begin
            if (!rst_n)       capt_q <= '0;
            else if (capt_ev) capt_q <= count_q;
        end

        AST_CAPT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            capt_ev |=> (capt_q == $past(count_q))); // R9
    end else begin : g_nocapt
        logic unused_capt;
        assign unused_capt = capt_pin;
        assign capt_ev     = 1'b0;
        assign capt_q      = '0;
    end

    assign unf_irq  = ctrl_q.unf_flag & ctrl_q.unie;
    assign capt_irq = ctrl_q.capt_flag & (ctrl_q.capt_mode == 2'b11);

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !count_wr && count_q != '0) |=> (count_q == $past(count_q) - 1'b1)); // R2
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !count_wr) |=> $stable(count_q)); // R2
    AST_RELOAD_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (count_q == $past(reload_q))); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.unf_flag && !(ctrl_wr && !wd.unf_flag)) |=> ctrl_q.unf_flag); // R5
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> ctrl_q.unf_flag); // R6
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && ctrl_q.unie && !ctrl_wr) |=> unf_irq); // R7
endmodule

// File: rtl/tmr_unit.sv
// Top: register port, run register, shared prescaler and NCH channels; the last
// channel captures. Assumes ADDR_W covers 4+4*NCH words and read data is registered.
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int CNT_W  = 32,
    parameter int NDIV   = 5,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              reg_rvalid,
    input  logic [NCH-1:0]    ext_clk_i,
    input  logic              capt_i,
    output logic [NCH-1:0]    unf_irq_o,
    output logic              capt_irq_o
);
    logic [NCH-1:0]   start_q;
    logic [NDIV-1:0]  div_tick;
    logic [CNT_W-1:0] reload_a [NCH];
    logic [CNT_W-1:0] count_a  [NCH];
    logic [CNT_W-1:0] capt_a   [NCH];
    ctrl_t            ctrl_a   [NCH];
    logic [NCH-1:0]   capt_irq_a;
    logic [CNT_W-1:0] rd_mux;

    // Run register at word 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                        start_q <= '0;
        else if (reg_wr && reg_addr == '0) start_q <= reg_wdata[NCH-1:0];
    end

    tmr_prescale #(.NDIV(NDIV)) u_pre (.clk(clk), .rst_n(rst_n), .tick(div_tick));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int BASE = CH_BASE + CH_STRIDE * c;
        tmr_channel #(.CNT_W(CNT_W), .NDIV(NDIV), .HAS_CAPT(c == NCH - 1)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(start_q[c]), .div_tick(div_tick),
            .ext_pin(ext_clk_i[c]), .capt_pin(capt_i),
            .reload_wr(reg_wr && reg_addr == ADDR_W'(BASE + OFS_RELOAD)),
            .count_wr (reg_wr && reg_addr == ADDR_W'(BASE + OFS_COUNT)),
            .ctrl_wr  (reg_wr && reg_addr == ADDR_W'(BASE + OFS_CTRL)),
            .wdata(reg_wdata), .reload_q(reload_a[c]), .count_q(count_a[c]),
            .capt_q(capt_a[c]), .ctrl_q(ctrl_a[c]),
            .unf_irq(unf_irq_o[c]), .capt_irq(capt_irq_a[c])
        );
    end

    assign capt_irq_o = |capt_irq_a;

    // Decode the read address into one word.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == '0) rd_mux[NCH-1:0] = start_q;
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFS_RELOAD)) rd_mux = reload_a[c];
            if (reg_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFS_COUNT))  rd_mux = count_a[c];
            if (reg_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFS_CTRL))   rd_mux = CNT_W'(ctrl_a[c]);
            if (reg_addr == ADDR_W'(CH_BASE + CH_STRIDE * c + OFS_CAPT))   rd_mux = capt_a[c];
        end
    end

    // Register read data and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

    AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid); // R11
    AST_RVALID_ONLY_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid); // R11
endmodule

// File: tb/tmr_unit_tb_top.sv
module tmr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [2:0]  ext_clk = '0;
    logic        capt = 1'b0;
    logic [2:0]  unf_irq;
    logic        capt_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    tmr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .ext_clk_i(ext_clk), .capt_i(capt), .unf_irq_o(unf_irq), .capt_irq_o(capt_irq)
    );

    function automatic logic [31:0] cfg(input int cs, input int edg, input int unie,
                                        input int cmode, input int uflag, input int cflag);
        return 32'((cflag << 9) | (uflag << 8) | (cmode << 6) | (unie << 5) | (edg << 3) | cs);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Driver: issue a read and queue its expected word for the monitor.
    task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string req);
        item_t it;
        it.exp = e; it.req = req;
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        sb_q.push_back(it);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pin_chk(input logic act, input logic e, input string req);
        n_chk++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, e);
        end
    endtask

    // Run the channels in mask for exactly n counted clock edges.
    task automatic run_for(input logic [2:0] mask, input int n);
        wr(4'd0, {29'd0, mask});
        repeat (n - 2) @(negedge clk);
        wr(4'd0, 32'd0);
    endtask

    task automatic ext_pulses(input int ch, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk[ch] = 1'b1;
            repeat (8) @(negedge clk);
            ext_clk[ch] = 1'b0;
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic capt_pulse();
        @(negedge clk); capt = 1'b1;
        repeat (8) @(negedge clk);
        capt = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // Monitor: pop and compare each returned read (R11 timing included).
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R11: unexpected read data %h expected none", reg_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (reg_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.req, reg_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        pin_chk(unf_irq[0] | unf_irq[1] | unf_irq[2], 1'b0, "R1");
        pin_chk(capt_irq, 1'b0, "R1");
        rd_exp(4'd5, 32'hFFFF_FFFF, "R1");
        rd_exp(4'd4, 32'hFFFF_FFFF, "R1");
        rd_exp(4'd14, 32'h0, "R1");
        rd_exp(4'd0, 32'h0, "R1");
        @(negedge clk);
        pin_chk(reg_rvalid, 1'b0, "R11");

        // R10 independent loads, R2 and R3 divide by 4
        wr(4'd4, 32'd7);
        wr(4'd5, 32'd100);
        wr(4'd6, cfg(0, 0, 0, 0, 0, 0));
        run_for(3'b001, 40);
        rd_exp(4'd5, 32'd90, "R2");
        rd_exp(4'd4, 32'd7, "R10");
        repeat (20) @(negedge clk);
        rd_exp(4'd5, 32'd90, "R2");
        wr(4'd6, cfg(1, 0, 0, 0, 0, 0));
        run_for(3'b001, 160);
        rd_exp(4'd5, 32'd80, "R3");
        wr(4'd6, cfg(2, 0, 0, 0, 0, 0));
        run_for(3'b001, 256);
        rd_exp(4'd5, 32'd76, "R3");

        // R4 reload and R5 flag
        wr(4'd6, cfg(0, 0, 0, 0, 0, 0));
        wr(4'd4, 32'd5);
        wr(4'd5, 32'd2);
        run_for(3'b001, 16);
        rd_exp(4'd5, 32'd4, "R4");
        rd_exp(4'd6, 32'h100, "R5");
        pin_chk(unf_irq[0], 1'b0, "R7");
        run_for(3'b001, 20);
        rd_exp(4'd5, 32'd5, "R4");

        // R7 gating, R6 clearing
        wr(4'd6, cfg(0, 0, 1, 0, 1, 0));
        pin_chk(unf_irq[0], 1'b1, "R7");
        wr(4'd6, cfg(0, 0, 1, 0, 0, 0));
        pin_chk(unf_irq[0], 1'b0, "R6");
        rd_exp(4'd6, 32'h020, "R6");
        wr(4'd6, cfg(0, 0, 1, 0, 1, 0));
        rd_exp(4'd6, 32'h020, "R6");
        pin_chk(unf_irq[0], 1'b0, "R6");

        // R8 external edges on channel 1
        wr(4'd9, 32'd50);
        wr(4'd10, cfg(7, 0, 0, 0, 0, 0));
        wr(4'd0, 32'd2);
        ext_pulses(1, 3);
        rd_exp(4'd9, 32'd47, "R8");
        wr(4'd10, cfg(7, 1, 0, 0, 0, 0));
        ext_pulses(1, 3);
        rd_exp(4'd9, 32'd44, "R8");
        wr(4'd10, cfg(7, 2, 0, 0, 0, 0));
        ext_pulses(1, 3);
        rd_exp(4'd9, 32'd38, "R8");
        wr(4'd0, 32'd0);

        // R6 underflow coinciding with a clearing write
        wr(4'd9, 32'd0);
        wr(4'd8, 32'd9);
        wr(4'd10, cfg(7, 0, 0, 0, 0, 0));
        wr(4'd0, 32'd2);
        @(negedge clk); ext_clk[1] = 1'b1;
        @(negedge clk);
        wr(4'd10, cfg(7, 0, 0, 0, 0, 0));
        rd_exp(4'd10, 32'h107, "R6");
        rd_exp(4'd9, 32'd9, "R4");
        ext_clk[1] = 1'b0;
        repeat (8) @(negedge clk);
        wr(4'd0, 32'd0);

        // R9 capture on channel 2
        wr(4'd13, 32'h1234);
        wr(4'd14, cfg(0, 0, 0, 3, 0, 0));
        capt_pulse();
        rd_exp(4'd15, 32'h1234, "R9");
        rd_exp(4'd14, 32'h2C0, "R9");
        pin_chk(capt_irq, 1'b1, "R9");
        wr(4'd14, cfg(0, 0, 0, 3, 0, 0));
        pin_chk(capt_irq, 1'b0, "R9");
        wr(4'd14, cfg(0, 0, 0, 2, 0, 0));
        wr(4'd13, 32'h55);
        capt_pulse();
        rd_exp(4'd15, 32'h55, "R9");
        rd_exp(4'd14, 32'h280, "R9");
        pin_chk(capt_irq, 1'b0, "R9");
        wr(4'd14, 32'h0);
        wr(4'd13, 32'h77);
        capt_pulse();
        rd_exp(4'd15, 32'h55, "R9");
        rd_exp(4'd14, 32'h0, "R9");
        wr(4'd6, cfg(0, 0, 0, 3, 0, 0));
        rd_exp(4'd6, 32'h0, "R9");

        repeat (5) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R11: got %0d pending reads expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule